// File: doc/BRIEF.md
# Strobed Overvoltage Filter with Blanking Select

This block is the digital filter behind an output overvoltage protection in a quasi-resonant switching regulator controller. After each turn-off of the power switch it waits a fixed strobe delay. It then takes exactly one sample of a digitized overvoltage comparator. It also takes one sample of a second comparator that reports whether the auxiliary winding voltage is above 1 V.

Overvoltage samples are counted. An oscillator cycle that ends without any overvoltage sample clears the count. When four overvoltage samples arrive in a row, the block raises a fault to the power sequencer, which stops switching and starts auto-restart. The auxiliary-voltage sample selects the blanking time for the next switching cycle: a high sample selects the short blanking time and a low sample selects the long one.

The reset input is held while the supply is in undervoltage. It returns the block to its initial state.

Top module: `ovp_strobe_filter`

## Requirements
- R1: While `rst` is high, and after it is released with no other input activity, `ovp_count` is 0, `ovp_fault` is 0 and `blank_short` is 0, which selects the long blanking time.
- R2: A gate-off pulse sampled at clock edge k causes one sample of `ovp_cmp` and `aux_hi_cmp` at edge k+STROBE_CYCLES (default 275, about 2.2 us at 125 MHz). The comparator values at any other edge have no effect.
- R3: A sample with `ovp_cmp` = 1 raises `ovp_count` by exactly one at the sample edge, and the output shows the new value right after that edge.
- R4: When `osc_cycle_end` is high at an edge and no overvoltage sample was taken since the previous `osc_cycle_end` pulse, `ovp_count` becomes 0. An overvoltage sample at the same edge as `osc_cycle_end` counts for the cycle that is ending, so it increments the count and does not clear it.
- R5: `ovp_fault` goes to 1 at the edge where `ovp_count` reaches OVP_LIMIT (default 4). It stays at 1 until `rst`, even if the count is later cleared.
- R6: `ovp_count` saturates at OVP_LIMIT. Further overvoltage samples leave it at OVP_LIMIT and never wrap it.
- R7: At each sample edge, `blank_short` takes the value of `aux_hi_cmp`: 1 selects the short blanking time and 0 selects the long one. Between samples it holds its value, whatever `aux_hi_cmp` and `osc_cycle_end` do.
- R8: Only one sample is taken per gate-off pulse, however long the off-time lasts. A new gate-off pulse that arrives before the pending sample restarts the strobe delay from that pulse.
- R9: Asserting `rst` in any state clears the count, the fault and the blank-select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Asynchronous active-high clear, held during undervoltage |
| gate_off_edge | input | 1 | One-cycle pulse when the power switch turns off |
| osc_cycle_end | input | 1 | One-cycle pulse at the end of each oscillator cycle |
| ovp_cmp | input | 1 | Overvoltage comparator output, 1 = above threshold |
| aux_hi_cmp | input | 1 | Auxiliary voltage above 1 V comparator output |
| ovp_fault | output | 1 | Sticky overvoltage fault to the sequencer |
| blank_short | output | 1 | 1 = short blanking time, 0 = long blanking time |
| ovp_count | output | $clog2(OVP_LIMIT+1) | Consecutive overvoltage sample count |

## Verification
A strobe timer that is off by one cycle shows at the ports right away: the count or the blank-select bit changes at the wrong edge. The bench exposes this by holding the comparators at the opposite value everywhere except the one intended sample edge. A stale "overvoltage seen" flag shows up at the next oscillator-cycle end, either as a count that is kept when it should be cleared or cleared when it should be kept. A wrapping or non-sticky counter shows up within one or two samples after the fourth one, as a count below the limit or a fault that drops.

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter #(
  parameter int STROBE_CYCLES = 275,
  parameter int OVP_LIMIT     = 4,
  localparam int CNT_W        = $clog2(OVP_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_off_edge,
  input  logic             osc_cycle_end,
  input  logic             ovp_cmp,
  input  logic             aux_hi_cmp,
  output logic             ovp_fault,
  output logic             blank_short,
  output logic [CNT_W-1:0] ovp_count
);

  localparam int TMR_W = $clog2(STROBE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OVP_LIMIT);

  logic [TMR_W-1:0] tmr;
  logic             armed;
  logic             seen;
  logic             strobe;
  logic             hit;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;

  assign strobe  = armed && (tmr == '0);
  assign hit     = strobe && ovp_cmp;
  assign cnt_inc = (hit && ovp_count != LIMIT) ? ovp_count + CNT_W'(1) : ovp_count;
  assign cnt_nxt = (osc_cycle_end && !(seen || hit)) ? '0 : cnt_inc;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      armed <= 1'b0;
      tmr   <= '0;
    end else if (gate_off_edge) begin
      armed <= 1'b1;
      tmr   <= TMR_W'(STROBE_CYCLES - 1);
    end else if (strobe) begin
      armed <= 1'b0;
    end else if (armed) begin
      tmr <= tmr - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ovp_count   <= '0;
      seen        <= 1'b0;
      ovp_fault   <= 1'b0;
      blank_short <= 1'b0;
    end else begin
      ovp_count <= cnt_nxt;
      seen      <= osc_cycle_end ? 1'b0 : (seen || hit);
      ovp_fault <= ovp_fault || (cnt_nxt == LIMIT);
      if (strobe) blank_short <= aux_hi_cmp;
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    ovp_count <= LIMIT); // R6
  AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ovp_count > $past(ovp_count)) |-> (ovp_count == $past(ovp_count) + CNT_W'(1))); // R3
  AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (ovp_count == LIMIT) |-> ovp_fault); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(ovp_fault) |-> ovp_fault); // R5
  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe) |-> $stable(blank_short)); // R7
  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (strobe && !gate_off_edge) |=> !strobe); // R8

endmodule

// File: tb/tb_ovp_strobe_filter.sv
module tb_ovp_strobe_filter;
  localparam int S = 275;

  logic clk = 0;
  logic rst = 1;
  logic gate_off_edge = 0;
  logic osc_cycle_end = 0;
  logic ovp_cmp = 0;
  logic aux_hi_cmp = 0;
  logic ovp_fault;
  logic blank_short;
  logic [2:0] ovp_count;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  ovp_strobe_filter #(.STROBE_CYCLES(S), .OVP_LIMIT(4)) dut (
    .clk(clk), .rst(rst), .gate_off_edge(gate_off_edge), .osc_cycle_end(osc_cycle_end),
    .ovp_cmp(ovp_cmp), .aux_hi_cmp(aux_hi_cmp), .ovp_fault(ovp_fault),
    .blank_short(blank_short), .ovp_count(ovp_count));

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk) rst = 1;
    @(negedge clk);
    @(negedge clk) rst = 0;
  endtask

  task automatic osc_pulse();
    @(negedge clk) osc_cycle_end = 1;
    @(negedge clk) osc_cycle_end = 0;
  endtask

  // gate-off pulse, then the comparators take ov/hi only for the sample edge
  task automatic sample(input logic ov, input logic hi, input logic with_osc);
    @(negedge clk) begin gate_off_edge = 1; ovp_cmp = ~ov; aux_hi_cmp = ~hi; end
    @(negedge clk) gate_off_edge = 0;
    repeat (S - 1) @(negedge clk);
    ovp_cmp = ov; aux_hi_cmp = hi; osc_cycle_end = with_osc;
    @(negedge clk) begin ovp_cmp = ~ov; aux_hi_cmp = ~hi; osc_cycle_end = 0; end
  endtask

  task automatic t_reset();
    chk("R1 count in reset", ovp_count, 0);
    chk("R1 fault in reset", ovp_fault, 0);
    chk("R1 blank long in reset", blank_short, 0);
    do_reset();
    repeat (3) @(negedge clk);
    chk("R1 count after reset", ovp_count, 0);
    chk("R1 fault after reset", ovp_fault, 0);
    chk("R1 blank after reset", blank_short, 0);
  endtask

  task automatic t_timing();
    do_reset();
    @(negedge clk) begin gate_off_edge = 1; ovp_cmp = 0; end
    @(negedge clk) begin gate_off_edge = 0; ovp_cmp = 1; end
    repeat (S - 2) @(negedge clk);
    ovp_cmp = 0;
    @(negedge clk);
    chk("R2 no sample one edge early", ovp_count, 0);
    ovp_cmp = 1;
    @(negedge clk) ovp_cmp = 0;
    chk("R2 R3 sample at strobe edge", ovp_count, 1);
    ovp_cmp = 1;
    repeat (3 * S) @(negedge clk);
    ovp_cmp = 0;
    chk("R8 one sample per long off-time", ovp_count, 1);
  endtask

  task automatic t_clear();
    do_reset();
    sample(1, 0, 0);
    osc_pulse();
    chk("R4 count kept after cycle with ovp", ovp_count, 1);
    sample(0, 0, 0);
    chk("R4 low sample alone keeps count", ovp_count, 1);
    osc_pulse();
    chk("R4 count cleared after cycle without ovp", ovp_count, 0);
    sample(1, 0, 0);
    osc_pulse();
    sample(1, 0, 1);
    chk("R4 coincident sample counts", ovp_count, 2);
    osc_pulse();
    chk("R4 cycle after coincident clears", ovp_count, 0);
  endtask

  task automatic t_restart();
    do_reset();
    @(negedge clk) begin gate_off_edge = 1; ovp_cmp = 0; end
    @(negedge clk) gate_off_edge = 0;
    repeat (S / 2) @(negedge clk);
    gate_off_edge = 1;
    @(negedge clk) gate_off_edge = 0;
    repeat (S - 1) @(negedge clk);
    chk("R8 restarted delay not yet expired", ovp_count, 0);
    ovp_cmp = 1;
    @(negedge clk) ovp_cmp = 0;
    chk("R8 sample after restarted delay", ovp_count, 1);
  endtask

  task automatic t_fault();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      sample(1, 0, 0);
      osc_pulse();
    end
    chk("R5 no fault at three", ovp_fault, 0);
    sample(1, 0, 0);
    chk("R5 count reaches limit", ovp_count, 4);
    chk("R5 fault at four", ovp_fault, 1);
    osc_pulse();
    sample(1, 0, 0);
    chk("R6 count saturates", ovp_count, 4);
    osc_pulse();
    osc_pulse();
    chk("R5 count cleared by idle cycle", ovp_count, 0);
    chk("R5 fault sticky", ovp_fault, 1);
    do_reset();
    chk("R9 reset clears fault", ovp_fault, 0);
  endtask

  task automatic t_blank();
    do_reset();
    sample(0, 1, 0);
    chk("R7 short blank selected", blank_short, 1);
    aux_hi_cmp = 0;
    osc_pulse();
    repeat (20) @(negedge clk);
    chk("R7 blank holds between samples", blank_short, 1);
    sample(1, 0, 0);
    chk("R7 long blank selected", blank_short, 0);
    sample(1, 1, 0);
    do_reset();
    chk("R9 reset clears blank", blank_short, 0);
    chk("R9 reset clears count", ovp_count, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_timing();
    t_clear();
    t_restart();
    t_fault();
    t_blank();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule